// File: doc/BRIEF.md
# Extended-Precision versus Integer Comparator

This block orders an 80-bit extended-precision floating-point value, the current top of the register stack, against a signed integer operand of either 16 or 32 bits. Before comparing, the integer is converted without loss into the same extended format. The block then reports a three-bit condition code and raises three flags: invalid-operation, denormal-operand and stack fault. When the caller picks the popping variant, the block also asks the surrounding stack logic to pop one entry.

The block is used inside a floating-point execution unit. The issuing logic holds `op_valid` high for one cycle and presents the stack-top value, its empty tag, the integer, the width select and the pop select. One clock edge later the condition code and flags appear on registered outputs. They keep their values until the next operation. The pop request is a pulse in that same cycle. The block does no stack bookkeeping and no memory access.

Top module: `fpint_cmp`

## Requirements
- R1: After reset, `cc` is 3'b000, every flag is 0 and `pop_req` is 0.
- R2: With `int_wide`=0, only `int_opnd[15:0]` is used, read as a two's-complement value. Bits [31:16] have no effect on the result.
- R3: With `int_wide`=1, all 32 bits of `int_opnd` are read as a two's-complement value. The comparison is exact for every value in that range.
- R4: `cc` is {C3,C2,C0}. It is 3'b000 when the stack-top value is greater than the integer, 3'b001 when it is less, and 3'b100 when they are equal.
- R5: A stack-top value of zero equals an integer of zero whatever the zero's sign. The sign of a zero never changes the result.
- R6: Some stack-top values give `cc`=3'b111 and `flag_invalid`=1. These are a quiet NaN (exponent all ones, mantissa bits [63:62]=11 with a nonzero fraction), a signalling NaN (bits [63:62]=10, nonzero fraction), and an unsupported encoding (nonzero exponent with mantissa bit 63 = 0).
- R7: Positive infinity (exponent all ones, mantissa 64'h8000_0000_0000_0000) is greater than every integer. Negative infinity is less than every integer. Neither raises a flag.
- R8: A denormal stack-top value (exponent zero, nonzero mantissa) sets `flag_denorm`=1 and still gives an ordered result by value.
- R9: When `st0_empty`=1, the result is `cc`=3'b111 with `flag_invalid`=1, `flag_stack_fault`=1 and `flag_denorm`=0. This holds whatever `st0_val` contains. `flag_stack_fault` is 0 for every operation with a non-empty stack top.
- R10: `pop_req` is high for exactly the cycle after an operation issued with `pop_sel`=1. It stays low after an operation with `pop_sel`=0.
- R11: Results appear one clock after `op_valid`. While `op_valid` is low, `cc` and the flags hold their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Issues one comparison this cycle |
| st0_val | input | 80 | Stack-top value: sign, 15-bit exponent, 64-bit mantissa with explicit integer bit |
| st0_empty | input | 1 | Stack-top register is tagged empty |
| int_opnd | input | 32 | Integer operand |
| int_wide | input | 1 | 1: 32-bit integer, 0: 16-bit integer in bits [15:0] |
| pop_sel | input | 1 | Popping variant |
| cc | output | 3 | Condition code {C3,C2,C0} |
| flag_invalid | output | 1 | Invalid-operation flag |
| flag_denorm | output | 1 | Denormal-operand flag |
| flag_stack_fault | output | 1 | Stack fault (underflow) flag |
| pop_req | output | 1 | Request to pop one stack entry |

## Verification
A fault in the integer normaliser would show as a wrong exponent or a wrong mantissa. That error appears in `cc` on the cycle after the operation, but only for integers on either side of the faulty leading-zero count. For this reason the sweep crosses integers at powers-of-two boundaries with stack values that lie half a unit away from them. A faulty class decode would show as a wrong flag or an ordered code where 3'b111 is expected, one cycle after issue. A missing clock enable would show as the outputs changing on the next idle cycle.

// File: rtl/fpint_pkg.sv
package fpint_pkg;
  localparam int EXP_W    = 15;
  localparam int MAN_W    = 64;
  localparam int EXP_BIAS = 16383;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [MAN_W-1:0] man;
  } ext_t;

  typedef enum logic [2:0] {
    CC_GT = 3'b000,
    CC_LT = 3'b001,
    CC_EQ = 3'b100,
    CC_UN = 3'b111
  } cc_e;

  typedef struct packed {
    logic is_zero;
    logic is_denorm;
    logic is_inf;
    logic is_nan;
    logic is_snan;
    logic is_unsup;
  } cls_t;
endpackage

// File: rtl/int_widen.sv
module int_widen
  import fpint_pkg::*;
#(
  parameter int INT_W    = 32,
  parameter int NARROW_W = 16
) (
  input  logic [INT_W-1:0] int_raw,
  input  logic             wide_sel,
  output ext_t             ext_val
);
  localparam int LZ_W = $clog2(INT_W + 1);

  logic [INT_W-1:0] sval;
  logic [INT_W-1:0] mag;
  logic [LZ_W-1:0]  lz;
  logic [INT_W-1:0] norm;
  logic             neg;

  function automatic logic [LZ_W-1:0] lead_zeros(input logic [INT_W-1:0] x);
    logic [LZ_W-1:0] cnt;
    logic            hit;
    cnt = '0;
    hit = 1'b0;
    for (int i = INT_W - 1; i >= 0; i--) begin
      if (!hit && x[i]) hit = 1'b1;
      if (!hit) cnt = cnt + 1'b1;
    end
    return cnt;
  endfunction

  always_comb begin
    if (wide_sel) sval = int_raw;
    else          sval = {{(INT_W-NARROW_W){int_raw[NARROW_W-1]}}, int_raw[NARROW_W-1:0]};
    neg  = sval[INT_W-1];
    mag  = neg ? (~sval + 1'b1) : sval;
    lz   = lead_zeros(mag);
    norm = mag << lz;
    if (mag == '0) begin
      ext_val = '0;
    end else begin
      ext_val.sign = neg;
      ext_val.exp  = EXP_W'(EXP_BIAS + INT_W - 1 - int'(lz));
      ext_val.man  = {norm, {(MAN_W-INT_W){1'b0}}};
    end
  end
endmodule

// File: rtl/fpx_classify.sv
module fpx_classify
  import fpint_pkg::*;
(
  input  ext_t v,
  output cls_t c
);
  logic exp_all1, exp_all0, jbit, frac_nz;

  always_comb begin
    exp_all1    = &v.exp;
    exp_all0    = ~|v.exp;
    jbit        = v.man[MAN_W-1];
    frac_nz     = |v.man[MAN_W-2:0];
    c.is_zero   = exp_all0 && (v.man == '0);
    c.is_denorm = exp_all0 && (v.man != '0);
    c.is_unsup  = !exp_all0 && !jbit;
    c.is_inf    = exp_all1 && jbit && !frac_nz;
    c.is_nan    = exp_all1 && jbit && frac_nz;
    c.is_snan   = exp_all1 && jbit && frac_nz && !v.man[MAN_W-2];
  end
endmodule

// File: rtl/fpx_order.sv
module fpx_order
  import fpint_pkg::*;
(
  input  ext_t a,
  input  ext_t b,
  output cc_e  rel
);
  logic [EXP_W+MAN_W-1:0] ma, mb;
  logic a_zero, b_zero;

  always_comb begin
    ma     = {a.exp, a.man};
    mb     = {b.exp, b.man};
    a_zero = (ma == '0);
    b_zero = (mb == '0);
    if (a_zero && b_zero)      rel = CC_EQ;
    else if (a.sign != b.sign) rel = a.sign ? CC_LT : CC_GT;
    else if (ma == mb)         rel = CC_EQ;
    else if (ma < mb)          rel = a.sign ? CC_GT : CC_LT;
    else                       rel = a.sign ? CC_LT : CC_GT;
  end
endmodule

// File: rtl/fpint_cmp.sv
module fpint_cmp
  import fpint_pkg::*;
#(
  parameter int INT_W    = 32,
  parameter int NARROW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [79:0]      st0_val,
  input  logic             st0_empty,
  input  logic [INT_W-1:0] int_opnd,
  input  logic             int_wide,
  input  logic             pop_sel,
  output logic [2:0]       cc,
  output logic             flag_invalid,
  output logic             flag_denorm,
  output logic             flag_stack_fault,
  output logic             pop_req
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  ext_t       st0_x, int_x;
  cls_t       st0_cls;
  cc_e        rel;
  cc_e        cc_d, cc_q;
  logic       inv_d, den_d, sf_d;
  logic       inv_q, den_q, sf_q, pop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign st0_x = st0_val;

  int_widen #(.INT_W(INT_W), .NARROW_W(NARROW_W)) widen_i (
    .int_raw (int_opnd),
    .wide_sel(int_wide),
    .ext_val (int_x)
  );

  fpx_classify class_i (
    .v(st0_x),
    .c(st0_cls)
  );

  fpx_order order_i (
    .a  (st0_x),
    .b  (int_x),
    .rel(rel)
  );

  always_comb begin
    cc_d  = rel;
    inv_d = 1'b0;
    den_d = 1'b0;
    sf_d  = 1'b0;
    if (st0_empty) begin
      cc_d  = CC_UN;
      inv_d = 1'b1;
      sf_d  = 1'b1;
    end else if (st0_cls.is_nan || st0_cls.is_unsup) begin
      cc_d  = CC_UN;
      inv_d = 1'b1;
    end else begin
      den_d = st0_cls.is_denorm;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cc_q  <= CC_GT;
      inv_q <= 1'b0;
      den_q <= 1'b0;
      sf_q  <= 1'b0;
      pop_q <= 1'b0;
    end else begin
      pop_q <= op_valid && pop_sel;
      if (op_valid) begin
        cc_q  <= cc_d;
        inv_q <= inv_d;
        den_q <= den_d;
        sf_q  <= sf_d;
      end
    end
  end

  assign cc               = cc_q;
  assign flag_invalid     = inv_q;
  assign flag_denorm      = den_q;
  assign flag_stack_fault = sf_q;
  assign pop_req          = pop_q;

  // R4
  cc_legal_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cc inside {3'b000, 3'b001, 3'b100, 3'b111});

  // R6
  unord_inv_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cc == 3'b111) |-> flag_invalid);

  // R9
  sfault_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flag_stack_fault |-> (flag_invalid && !flag_denorm && cc == 3'b111));

  // R10
  pop_src_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pop_req |-> $past(op_valid && pop_sel));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$past(op_valid) |-> ($stable(cc) && $stable(flag_invalid) && $stable(flag_denorm)));
endmodule

// File: tb/fpint_cmp_tb_top.sv
module fpint_cmp_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [79:0] st0_val;
  logic        st0_empty;
  logic [31:0] int_opnd;
  logic        int_wide;
  logic        pop_sel;
  logic [2:0]  cc;
  logic        flag_invalid, flag_denorm, flag_stack_fault, pop_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpint_cmp dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .st0_val(st0_val),
    .st0_empty(st0_empty), .int_opnd(int_opnd), .int_wide(int_wide),
    .pop_sel(pop_sel), .cc(cc), .flag_invalid(flag_invalid),
    .flag_denorm(flag_denorm), .flag_stack_fault(flag_stack_fault),
    .pop_req(pop_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [79:0] dbl2ext(input real r);
    logic [63:0] b;
    int ee;
    b = $realtobits(r);
    if (b[62:52] == 11'd0) return {b[63], 79'd0};
    ee = int'(b[62:52]) - 1023 + 16383;
    return {b[63], 15'(ee), 1'b1, b[51:0], 11'd0};
  endfunction

  task automatic run_op(input logic [79:0] s, input logic emp, input logic [31:0] iv,
                        input logic wide, input logic pop);
    @(negedge clk);
    st0_val = s; st0_empty = emp; int_opnd = iv; int_wide = wide; pop_sel = pop;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic chk_res(input string req, input logic [2:0] ecc, input logic ei,
                         input logic ed, input logic es);
    chk({req, " cc"}, {29'd0, cc}, {29'd0, ecc});
    chk({req, " invalid"}, {31'd0, flag_invalid}, {31'd0, ei});
    chk({req, " denorm"}, {31'd0, flag_denorm}, {31'd0, ed});
    chk({req, " stack fault"}, {31'd0, flag_stack_fault}, {31'd0, es});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    real         rv [22];
    logic [31:0] iv [12];
    logic [79:0] qnan, snan, unsup, pinf, ninf, pden, nden, pseudo_inf;
    logic [2:0]  held;
    rv = '{0.0, 1.0, -1.0, 0.5, -0.5, 1.5, -1.5, 2.0, -2.0, 32767.0, -32768.0,
           32767.5, -32768.5, 2147483647.0, -2147483648.0, 2147483647.5,
           -2147483648.5, 4294967296.0, 1.0e12, -1.0e12, 12345.25, -1.0/1024.0};
    iv = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h2, 32'h0000_7FFF, 32'h0000_8000,
           32'hFFFF_8000, 32'h7FFF_FFFF, 32'h8000_0000, 32'hABCD_3039,
           32'h0001_0000, 32'hFFFF_FFFE};
    qnan       = {1'b0, 15'h7FFF, 64'hC000_0000_0000_0001};
    snan       = {1'b1, 15'h7FFF, 64'hA000_0000_0000_0000};
    unsup      = {1'b0, 15'd16383, 64'h4000_0000_0000_0000};
    pseudo_inf = {1'b0, 15'h7FFF, 64'h0};
    pinf       = {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000};
    ninf       = {1'b1, 15'h7FFF, 64'h8000_0000_0000_0000};
    pden       = {1'b0, 15'h0, 64'h0000_0000_0000_0001};
    nden       = {1'b1, 15'h0, 64'h0000_0000_0000_0001};

    rst_n = 1'b0; op_valid = 1'b0; st0_val = '0; st0_empty = 1'b0;
    int_opnd = '0; int_wide = 1'b0; pop_sel = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_res("R1", 3'b000, 1'b0, 1'b0, 1'b0);
    chk("R1 pop", {31'd0, pop_req}, 32'd0);

    // R2 / R3 / R4 sweep
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 22; a++) begin
        for (int k = 0; k < 12; k++) begin
          int ival;
          logic [2:0] e;
          ival = (m == 1) ? int'($signed(iv[k])) : int'($signed(iv[k][15:0]));
          if (rv[a] > $itor(ival))      e = 3'b000;
          else if (rv[a] < $itor(ival)) e = 3'b001;
          else                          e = 3'b100;
          run_op(dbl2ext(rv[a]), 1'b0, iv[k], m[0], 1'b0);
          chk_res((m == 1) ? "R3 R4 wide" : "R2 R4 narrow", e, 1'b0, 1'b0, 1'b0);
        end
      end
    end

    // R5 signed zeros
    run_op({1'b1, 79'd0}, 1'b0, 32'h0, 1'b1, 1'b0);
    chk_res("R5 -0 vs 0", 3'b100, 1'b0, 1'b0, 1'b0);
    run_op({1'b1, 79'd0}, 1'b0, 32'hFFFF_0000, 1'b0, 1'b0);
    chk_res("R5 -0 vs narrow 0", 3'b100, 1'b0, 1'b0, 1'b0);
    run_op({1'b1, 79'd0}, 1'b0, 32'h1, 1'b1, 1'b0);
    chk_res("R5 -0 vs 1", 3'b001, 1'b0, 1'b0, 1'b0);
    run_op({1'b1, 79'd0}, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0);
    chk_res("R5 -0 vs -1", 3'b000, 1'b0, 1'b0, 1'b0);

    // R6 unordered
    run_op(qnan, 1'b0, 32'h5, 1'b1, 1'b0);
    chk_res("R6 qnan", 3'b111, 1'b1, 1'b0, 1'b0);
    run_op(snan, 1'b0, 32'h0, 1'b0, 1'b0);
    chk_res("R6 snan", 3'b111, 1'b1, 1'b0, 1'b0);
    run_op(unsup, 1'b0, 32'h1, 1'b1, 1'b0);
    chk_res("R6 unsupported", 3'b111, 1'b1, 1'b0, 1'b0);
    run_op(pseudo_inf, 1'b0, 32'h1, 1'b1, 1'b0);
    chk_res("R6 pseudo inf", 3'b111, 1'b1, 1'b0, 1'b0);

    // R7 infinities
    run_op(pinf, 1'b0, 32'h7FFF_FFFF, 1'b1, 1'b0);
    chk_res("R7 +inf", 3'b000, 1'b0, 1'b0, 1'b0);
    run_op(ninf, 1'b0, 32'h8000_0000, 1'b1, 1'b0);
    chk_res("R7 -inf", 3'b001, 1'b0, 1'b0, 1'b0);

    // R8 denormals
    run_op(pden, 1'b0, 32'h0, 1'b1, 1'b0);
    chk_res("R8 +den vs 0", 3'b000, 1'b0, 1'b1, 1'b0);
    run_op(pden, 1'b0, 32'h1, 1'b1, 1'b0);
    chk_res("R8 +den vs 1", 3'b001, 1'b0, 1'b1, 1'b0);
    run_op(nden, 1'b0, 32'h0, 1'b0, 1'b0);
    chk_res("R8 -den vs 0", 3'b001, 1'b0, 1'b1, 1'b0);

    // R9 empty stack top
    run_op(dbl2ext(1.0), 1'b1, 32'h1, 1'b1, 1'b0);
    chk_res("R9 empty", 3'b111, 1'b1, 1'b0, 1'b1);
    run_op(pden, 1'b1, 32'h0, 1'b1, 1'b0);
    chk_res("R9 empty denormal", 3'b111, 1'b1, 1'b0, 1'b1);

    // R10 pop request
    run_op(dbl2ext(3.0), 1'b0, 32'h3, 1'b1, 1'b1);
    chk("R10 pop pulse", {31'd0, pop_req}, 32'd1);
    chk_res("R10 compare", 3'b100, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R10 pop one cycle", {31'd0, pop_req}, 32'd0);
    run_op(dbl2ext(3.0), 1'b0, 32'h3, 1'b1, 1'b0);
    chk("R10 no pop", {31'd0, pop_req}, 32'd0);

    // R11 hold while idle
    run_op(dbl2ext(-7.0), 1'b0, 32'h2, 1'b1, 1'b0);
    held = cc;
    chk("R11 latency", {29'd0, cc}, 32'd1);
    st0_val = qnan; st0_empty = 1'b1; int_opnd = 32'h0;
    repeat (3) @(negedge clk);
    chk_res("R11 hold", held, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule